// File: doc/BRIEF.md
# Power-of-Two Bus Clock Slowdown

This block slows the bus rate of a chip by a power of two under software control. It does not gate or switch a clock. It produces a one-cycle enable strobe, `bus_tick`, in the oscillator domain, and bus logic advances only on cycles where the strobe is high. With no slowdown the strobe fires on every second oscillator cycle, which is the undivided bus rate of half the oscillator frequency. A 3-bit exponent `n`, held in one 8-bit register, stretches the strobe period to `2 * 2^n` oscillator cycles, so the divisor is 2^n, from 2 up to 128. A zero exponent bypasses the slowdown.

Software reaches the register through a small read/write port. The register lives at offset 0xE0 inside an 11-bit (2 KB) window. The upper address bits of that window come from the `base_hi` input, so the whole window can be moved to any 2 KB-aligned address. A new exponent is stored at once and read back at once. The divider only picks it up at the end of the divided period that is running, so no strobe interval is ever cut short or stretched to an odd length.

Top module: `clkdiv_top`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and the divider is bypassed, so `bus_tick` is high on every second cycle, starting on the second cycle after reset is released.
- R2: With exponent n (1 to 7) in effect, `bus_tick` is high for exactly one cycle out of every 2^(n+1) cycles.
- R3: Bits 2..0 of the register hold the exponent. Bits 7..3 always read 0 and ignore written data.
- R4: A write takes effect only when `addr[15:11]` equals `base_hi` and `addr[10:0]` equals 0xE0. Any other address leaves the register unchanged.
- R5: A new exponent is applied only on the cycle after a `bus_tick`. If several writes land within one period, the last one written is the one used.
- R6: `rdata` shows the programmed exponent (zero-extended) whenever the address matches, even while the divider still runs on the old value. When the address does not match, `rdata` is 0.
- R7: `bus_tick` is never high on two consecutive cycles.
- R8: Changing `base_hi` moves the register. The old address no longer reads or writes it, and the new address does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| base_hi | input | 5 | Upper address bits of the relocatable 2 KB window |
| addr | input | 16 | Register access address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid when the address matches |
| bus_tick | output | 1 | One-cycle bus-rate enable |

## Verification
The hardest case to reach from the ports is a change of exponent in the middle of a long period, followed by a second write before that period ends. Only the later value may take effect, and only at the boundary. The stimulus starts from exponent 7, so each period lasts 256 cycles. It writes twice well inside one period and reads the register back between the writes. A cycle-accurate reference model follows the pending and active values apart and flags any strobe that moves early or late. The stimulus also relocates the window and writes at near-miss addresses to test the decode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int ADDR_W  = 16;
    parameter int DATA_W  = 8;
    parameter int SEL_W   = 3;
    parameter int WIN_W   = 11;
    parameter logic [WIN_W-1:0] REG_OFS = 11'h0E0;
    localparam int CNT_W  = (1 << SEL_W);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic hit;
        logic wr;
    } access_t;

    // last count of a divided period: period is 2^(sel+1) cycles
    function automatic cnt_t last_count(sel_t s);
        int unsigned p;
        p = 2 << s;
        return cnt_t'(p - 1);
    endfunction
endpackage

// File: rtl/clkdiv_regif.sv
module clkdiv_regif
    import clkdiv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-WIN_W-1:0] base_hi,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output sel_t                    prog_sel
);
    access_t acc;

    always_comb begin
        acc.hit = (addr[ADDR_W-1:WIN_W] == base_hi) && (addr[WIN_W-1:0] == REG_OFS);
        acc.wr  = acc.hit && wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prog_sel <= '0;
        else if (acc.wr)
            prog_sel <= wdata[SEL_W-1:0];
    end

    assign rdata = acc.hit ? DATA_W'(prog_sel) : '0;

    // R4: a write to a non-matching address leaves the register alone
    a_r4_miss_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !acc.hit) |=> $stable(prog_sel));

    // R1: reset clears the programmed exponent
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (prog_sel == '0));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t prog_sel,
    output logic bus_tick
);
    cnt_t cnt;
    sel_t act_sel;

    assign bus_tick = (cnt == last_count(act_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_sel <= '0;
        end else if (bus_tick) begin
            cnt     <= '0;
            act_sel <= prog_sel;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // R7: strobe is one cycle wide
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_tick |=> !bus_tick);

    // R5: active exponent changes only at a period boundary
    a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        !bus_tick |=> $stable(act_sel));

    // R1: bypassed and nothing pending, next strobe two cycles later
    a_r1_bypass_rate: assert property (@(posedge clk) disable iff (rst)
        (bus_tick && act_sel == '0 && prog_sel == '0) |=> ##1 bus_tick);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-WIN_W-1:0] base_hi,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic                    bus_tick
);
    sel_t prog_sel;

    clkdiv_regif u_regif (
        .clk      (clk),
        .rst      (rst),
        .base_hi  (base_hi),
        .addr     (addr),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .prog_sel (prog_sel)
    );

    clkdiv_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .prog_sel (prog_sel),
        .bus_tick (bus_tick)
    );

    // R3: unimplemented bits never read as one
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:SEL_W] == '0);
endmodule

// File: tb/tb_clkdiv_top.sv
module tb_clkdiv_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  base_hi = 5'd0;
    logic [15:0] addr = 16'h0000;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        bus_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state
    int m_cnt = 0, m_act = 0, m_prog = 0;
    bit started = 0;

    clkdiv_top dut (
        .clk(clk), .rst(rst), .base_hi(base_hi), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .bus_tick(bus_tick)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic bit m_hit();
        return (addr[15:11] == base_hi) && (addr[10:0] == 11'h0E0);
    endfunction

    // model: update on every edge, counter first using the old pending value
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_act = 0; m_prog = 0; started = 1;
        end else begin
            if (m_cnt == (2 << m_act) - 1) begin
                m_cnt = 0; m_act = m_prog;
            end else begin
                m_cnt++;
            end
            if (wr_en && m_hit()) m_prog = int'(wdata[2:0]);
        end
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog expired: actual cycle %0d expected < 200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            logic exp_tick;
            logic [7:0] exp_rd;
            exp_tick = (m_cnt == (2 << m_act) - 1);
            exp_rd   = m_hit() ? 8'(m_prog) : 8'h00;
            checks++;
            if (bus_tick !== exp_tick) begin
                fails++;
                $display("FAIL R1 R2 R5 R7 bus_tick cycle %0d: actual %b expected %b", cyc, bus_tick, exp_tick);
            end
            checks++;
            if (rdata !== exp_rd) begin
                fails++;
                $display("FAIL R3 R4 R6 R8 rdata cycle %0d: actual %h expected %h", cyc, rdata, exp_rd);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(logic [15:0] a, logic [7:0] exp, string tag);
        addr = a;
        @(negedge clk);
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s directed read %h: actual %h expected %h", tag, a, rdata, exp);
        end
        step(1);
    endtask

    // count strobes over a window and compare with the expected number
    task automatic tick_count(int n, int exp, string tag);
        int got = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_tick) got++;
        end
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s tick count: actual %0d expected %0d", tag, got, exp);
        end
        step(1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1: reset value and bypass rate
        rd_check(16'h00E0, 8'h00, "R1");
        tick_count(40, 20, "R1");
        // R2: exponent 3 -> period 16
        wr(16'h00E0, 8'h03);
        step(40);
        tick_count(160, 10, "R2");
        // R3: upper bits ignored
        wr(16'h00E0, 8'hF9);
        rd_check(16'h00E0, 8'h01, "R3");
        step(30);
        tick_count(80, 20, "R2");
        // R4: near-miss addresses do not write
        wr(16'h00E1, 8'h05);
        wr(16'h08E0, 8'h05);
        wr(16'h80E0, 8'h05);
        rd_check(16'h00E0, 8'h01, "R4");
        // R8: relocate the window
        base_hi = 5'd3;
        step(1);
        rd_check(16'h00E0, 8'h00, "R8");
        wr(16'h00E0, 8'h06);
        rd_check(16'h18E0, 8'h01, "R8");
        // R5/R6: long period, two writes inside it, read shows pending
        wr(16'h18E0, 8'h07);
        step(300);
        wr(16'h18E0, 8'h02);
        rd_check(16'h18E0, 8'h02, "R6");
        wr(16'h18E0, 8'h04);
        rd_check(16'h18E0, 8'h04, "R5");
        step(600);
        tick_count(320, 10, "R5");
        // back to bypass, then reset mid-run
        wr(16'h18E0, 8'h00);
        step(80);
        tick_count(20, 10, "R1");
        wr(16'h18E0, 8'h05);
        step(17);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        rd_check(16'h18E0, 8'h00, "R1");
        step(50);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule